// File: doc/BRIEF.md
# Track Phi Linearizer

This block takes the track traffic of one trigger crossing and turns each track's coarse azimuth into a single linear position. A crossing carries six tracks on three 13-bit channels. Each channel carries two tracks, one in each half of the crossing: tracks A, B and C travel on channels 0, 1 and 2 in the first half, and tracks D, E and F in the second half. Every channel word holds a 9-bit momentum field and a 4-bit segment code. The 9-bit momentum field is 7 magnitude bits plus a short flag and an isolation flag.

A separate 5-bit wedge code for each of the six tracks arrives in parallel. The block captures all six codes when a crossing begins. It then steers them so that each channel sees the wedge code of the track it is carrying in that half. For every channel it produces the position wedge*12 + segment (0..287) on 9 bits, using only shifts and adds over two pipeline stages. The momentum field is delayed by the same number of stages. A flag marks which half each output belongs to.

The block runs on one clock at the half-crossing rate. A phase bit toggles every cycle. A crossing-start strobe forces the phase back to the first half.

Top module: `trk_phi_linearizer`

## Requirements
- R1: Channel c's word occupies `chan_in[13c+12:13c]`, with the momentum field in bits [12:4] and the segment code in bits [3:0]. `pt_out[9c+8:9c]` equals the momentum field applied three clock edges earlier.
- R2: For input in a first-half cycle with a valid segment (0..11) and a valid wedge (0..23), `lin_out` of channel c equals wedge*12 + segment three edges later. The wedge used is that of track c (A, B or C), taken from `wedge_in[5c+4:5c]` at the last crossing start.
- R3: For input in a second-half cycle, channel c uses the wedge code of track c+3 (D, E or F), taken from `wedge_in[5(c+3)+4:5(c+3)]` at the last crossing start. All other rules are as in R2.
- R4: Wedge codes are captured only in a cycle where `xing_start` is 1. Changes on `wedge_in` in any other cycle have no effect on any output.
- R5: A cycle with `xing_start` = 1 is always treated as first half, even if the phase would otherwise have been second half. The cycle after it is second half.
- R6: A segment code of 12..15 sets `err_out[c]` and forces `lin_out` of that channel to 0, with the same three-edge latency.
- R7: A wedge code of 24..31 for the track in use sets `err_out[c]` and forces `lin_out` of that channel to 0.
- R8: While `rst` is held, all outputs are 0.
- R9: `out_half` is 0 for output from first-half input and 1 for output from second-half input, aligned with `pt_out` and `lin_out`. Without strobes it alternates every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-crossing rate clock |
| rst | input | 1 | Synchronous active-high reset |
| xing_start | input | 1 | Marks the first half of a crossing; wedge codes are captured in this cycle |
| chan_in | input | 39 | Three channel words, 13 bits each |
| wedge_in | input | 30 | Six wedge codes for tracks A..F, 5 bits each |
| pt_out | output | 27 | Delayed momentum fields, 9 bits per channel |
| lin_out | output | 27 | Linear positions, 9 bits per channel |
| err_out | output | 3 | Per-channel invalid segment or wedge flag |
| out_half | output | 1 | Half that the current outputs belong to |

## Verification
The hard case is a crossing start that arrives while the phase would have been in the second half. In that cycle the phase restart and the wedge reload fall together. The data from the previous half is still in the pipeline and must finish with the old codes, while the new word must pair with the new codes.

The bench provokes this with directed back-to-back strobes and with random strobes in mid-crossing during a long random run. It judges every output against a model that tracks phase and captured wedges on its own. Invalid segment and wedge codes are mixed into the same traffic, so forced zero outputs also coincide with the phase restarts.

// File: rtl/phi_lin_pkg.sv
package phi_lin_pkg;
    localparam int N_CH        = 3;
    localparam int NTRK        = 2 * N_CH;
    localparam int PT_W        = 9;
    localparam int SEG_W       = 4;
    localparam int WEDGE_W     = 5;
    localparam int WORD_W      = PT_W + SEG_W;
    localparam int W3_W        = WEDGE_W + 2;
    localparam int LIN_W       = WEDGE_W + 4;
    localparam int SEG_COUNT   = 12;
    localparam int WEDGE_COUNT = 24;

    typedef struct packed {
        logic [PT_W-1:0]  pt;
        logic [SEG_W-1:0] seg;
    } chan_word_t;

    typedef struct packed {
        logic [PT_W-1:0]  pt;
        logic [SEG_W-1:0] seg;
        logic [W3_W-1:0]  w3;
        logic             bad;
    } stage1_t;

    // wedge * 3 as (wedge << 1) + wedge
    function automatic logic [W3_W-1:0] times3(input logic [WEDGE_W-1:0] w);
        return {1'b0, w, 1'b0} + {2'b00, w};
    endfunction

    // (w3 << 2) + segment = wedge * 12 + segment
    function automatic logic [LIN_W-1:0] fold(input logic [W3_W-1:0] w3,
                                              input logic [SEG_W-1:0] seg);
        return {w3, 2'b00} + LIN_W'(seg);
    endfunction
endpackage

// File: rtl/phi_phase_sel.sv
module phi_phase_sel
    import phi_lin_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      xing_start,
    input  logic [NTRK*WEDGE_W-1:0]   wedge_in,
    output logic                      half_o,
    output logic [N_CH*WEDGE_W-1:0]   wedge_sel,
    output logic [NTRK*WEDGE_W-1:0]   wedge_hold
);
    logic phase_q;
    logic cur_half;

    assign cur_half = xing_start ? 1'b0 : phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= 1'b0;
            half_o     <= 1'b0;
            wedge_hold <= '0;
        end else begin
            phase_q <= ~cur_half;
            half_o  <= cur_half;
            if (xing_start)
                wedge_hold <= wedge_in;
        end
    end

    // steer the held codes into step with the latched channel words
    for (genvar c = 0; c < N_CH; c++) begin : g_sel
        assign wedge_sel[c*WEDGE_W +: WEDGE_W] = half_o
            ? wedge_hold[(c+N_CH)*WEDGE_W +: WEDGE_W]
            : wedge_hold[c*WEDGE_W +: WEDGE_W];
    end
endmodule

// File: rtl/phi_lin_lane.sv
module phi_lin_lane
    import phi_lin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_W-1:0]  word_in,
    input  logic [WEDGE_W-1:0] wedge,
    output logic [PT_W-1:0]    pt_o,
    output logic [LIN_W-1:0]   lin_o,
    output logic               err_o
);
    chan_word_t word_q;
    stage1_t    s1;
    logic       bad;

    assign bad = (word_q.seg >= SEG_W'(SEG_COUNT)) ||
                 (wedge >= WEDGE_W'(WEDGE_COUNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            s1     <= '0;
            pt_o   <= '0;
            lin_o  <= '0;
            err_o  <= 1'b0;
        end else begin
            word_q   <= chan_word_t'(word_in);
            s1.pt    <= word_q.pt;
            s1.seg   <= word_q.seg;
            s1.w3    <= times3(wedge);
            s1.bad   <= bad;
            pt_o     <= s1.pt;
            err_o    <= s1.bad;
            lin_o    <= s1.bad ? '0 : fold(s1.w3, s1.seg);
        end
    end
endmodule

// File: rtl/trk_phi_linearizer.sv
module trk_phi_linearizer
    import phi_lin_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     xing_start,
    input  logic [N_CH*WORD_W-1:0]   chan_in,
    input  logic [NTRK*WEDGE_W-1:0]  wedge_in,
    output logic [N_CH*PT_W-1:0]     pt_out,
    output logic [N_CH*LIN_W-1:0]    lin_out,
    output logic [N_CH-1:0]          err_out,
    output logic                     out_half
);
    logic                     half0;
    logic                     half1;
    logic [N_CH*WEDGE_W-1:0]  wedge_sel;
    logic [NTRK*WEDGE_W-1:0]  wedge_hold;

    phi_phase_sel u_phase (
        .clk        (clk),
        .rst        (rst),
        .xing_start (xing_start),
        .wedge_in   (wedge_in),
        .half_o     (half0),
        .wedge_sel  (wedge_sel),
        .wedge_hold (wedge_hold)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        phi_lin_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .word_in (chan_in[c*WORD_W +: WORD_W]),
            .wedge   (wedge_sel[c*WEDGE_W +: WEDGE_W]),
            .pt_o    (pt_out[c*PT_W +: PT_W]),
            .lin_o   (lin_out[c*LIN_W +: LIN_W]),
            .err_o   (err_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half1    <= 1'b0;
            out_half <= 1'b0;
        end else begin
            half1    <= half0;
            out_half <= half1;
        end
    end
endmodule

// File: rtl/phi_lin_checker.sv
module phi_lin_checker
    import phi_lin_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     xing_start,
    input logic [N_CH*WORD_W-1:0]   chan_in,
    input logic [NTRK*WEDGE_W-1:0]  wedge_in,
    input logic [NTRK*WEDGE_W-1:0]  wedge_hold,
    input logic [N_CH*PT_W-1:0]     pt_out,
    input logic [N_CH*LIN_W-1:0]    lin_out,
    input logic [N_CH-1:0]          err_out,
    input logic                     out_half
);
    logic [2:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt != 3'd7) cnt <= cnt + 3'd1;
    end

    assert_rst_quiet_R8: assert property (@(posedge clk)
        rst |=> (pt_out == '0 && lin_out == '0 && err_out == '0 && !out_half));

    assert_wedge_keep_R4: assert property (@(posedge clk) disable iff (rst)
        !xing_start |=> $stable(wedge_hold));

    assert_wedge_load_R4: assert property (@(posedge clk) disable iff (rst)
        xing_start |=> wedge_hold == $past(wedge_in));

    assert_restart_half_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 3'd4 && $past(xing_start, 3)) |-> !out_half);

    assert_half_toggle_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 3'd5 && !$past(xing_start, 3)) |-> out_half != $past(out_half));

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        assert_pt_pass_R1: assert property (@(posedge clk) disable iff (rst)
            cnt >= 3'd4 |-> pt_out[c*PT_W +: PT_W] ==
                            $past(chan_in[c*WORD_W+SEG_W +: PT_W], 3));

        assert_err_zero_R6: assert property (@(posedge clk) disable iff (rst)
            err_out[c] |-> lin_out[c*LIN_W +: LIN_W] == '0);

        assert_lin_range_R2: assert property (@(posedge clk) disable iff (rst)
            !err_out[c] |-> lin_out[c*LIN_W +: LIN_W] <=
                            LIN_W'(WEDGE_COUNT*SEG_COUNT - 1));
    end
endmodule

bind trk_phi_linearizer phi_lin_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .xing_start (xing_start),
    .chan_in    (chan_in),
    .wedge_in   (wedge_in),
    .wedge_hold (wedge_hold),
    .pt_out     (pt_out),
    .lin_out    (lin_out),
    .err_out    (err_out),
    .out_half   (out_half)
);

// File: tb/trk_phi_linearizer_bench.sv
module trk_phi_linearizer_bench;
    import phi_lin_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                     rst;
    logic                     xing_start;
    logic [N_CH*WORD_W-1:0]   chan_in;
    logic [NTRK*WEDGE_W-1:0]  wedge_in;
    logic [N_CH*PT_W-1:0]     pt_out;
    logic [N_CH*LIN_W-1:0]    lin_out;
    logic [N_CH-1:0]          err_out;
    logic                     out_half;

    trk_phi_linearizer u_trk_phi_linearizer (
        .clk(clk), .rst(rst), .xing_start(xing_start), .chan_in(chan_in),
        .wedge_in(wedge_in), .pt_out(pt_out), .lin_out(lin_out),
        .err_out(err_out), .out_half(out_half)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    ph_next = 1'b0;
    int    mw[NTRK];
    int    e_pt[4][N_CH];
    int    e_lin[4][N_CH];
    int    e_err[4][N_CH];
    string e_req[4][N_CH];
    int    e_half[4];
    bit    e_vld[4];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lin_model(input int w, input int s);
        if (s >= SEG_COUNT || w >= WEDGE_COUNT) return 0;
        return w * 12 + s;
    endfunction

    function automatic logic [WORD_W-1:0] mk(input int pt, input int seg);
        return {PT_W'(pt), SEG_W'(seg)};
    endfunction

    function automatic logic [N_CH*WORD_W-1:0] ch3(input int s0, input int s1,
                                                   input int s2, input int p);
        return {mk(p + 2, s2), mk(p + 1, s1), mk(p, s0)};
    endfunction

    function automatic logic [NTRK*WEDGE_W-1:0] w6(input int a, input int b, input int c,
                                                   input int d, input int e, input int f);
        return {WEDGE_W'(f), WEDGE_W'(e), WEDGE_W'(d), WEDGE_W'(c), WEDGE_W'(b), WEDGE_W'(a)};
    endfunction

    function automatic logic [N_CH*WORD_W-1:0] rnd_ch();
        logic [N_CH*WORD_W-1:0] v;
        for (int c = 0; c < N_CH; c++) begin
            int seg;
            seg = ($urandom % 8 == 0) ? 12 + int'($urandom % 4) : int'($urandom % 12);
            v[c*WORD_W +: WORD_W] = mk(int'($urandom % 512), seg);
        end
        return v;
    endfunction

    function automatic logic [NTRK*WEDGE_W-1:0] rnd_w();
        logic [NTRK*WEDGE_W-1:0] v;
        for (int t = 0; t < NTRK; t++)
            v[t*WEDGE_W +: WEDGE_W] = WEDGE_W'(($urandom % 10 == 0) ?
                                      24 + int'($urandom % 8) : int'($urandom % 24));
        return v;
    endfunction

    task automatic compare(input int s);
        for (int c = 0; c < N_CH; c++) begin
            chk(int'(pt_out[c*PT_W +: PT_W]) == e_pt[s][c], {"R1 pt ", e_req[s][c]},
                int'(pt_out[c*PT_W +: PT_W]), e_pt[s][c]);
            chk(int'(lin_out[c*LIN_W +: LIN_W]) == e_lin[s][c], {"lin ", e_req[s][c]},
                int'(lin_out[c*LIN_W +: LIN_W]), e_lin[s][c]);
            chk(int'(err_out[c]) == e_err[s][c], {"err ", e_req[s][c]},
                int'(err_out[c]), e_err[s][c]);
        end
        chk(int'(out_half) == e_half[s], {"R9 half ", e_req[s][0]}, int'(out_half), e_half[s]);
    endtask

    task automatic drive(input bit s, input logic [N_CH*WORD_W-1:0] ch,
                         input logic [NTRK*WEDGE_W-1:0] w, input string tag);
        int  slot;
        bit  ph;
        @(negedge clk);
        if (e_vld[(cyc + 1) % 4]) compare((cyc + 1) % 4);
        xing_start = s;
        chan_in    = ch;
        wedge_in   = w;
        ph      = s ? 1'b0 : ph_next;
        ph_next = ~ph;
        if (s)
            for (int t = 0; t < NTRK; t++) mw[t] = int'(w[t*WEDGE_W +: WEDGE_W]);
        slot = cyc % 4;
        e_half[slot] = int'(ph);
        for (int c = 0; c < N_CH; c++) begin
            int wv, sg;
            string rq;
            wv = ph ? mw[c + N_CH] : mw[c];
            sg = int'(ch[c*WORD_W +: SEG_W]);
            e_pt[slot][c]  = int'(ch[c*WORD_W + SEG_W +: PT_W]);
            e_lin[slot][c] = lin_model(wv, sg);
            e_err[slot][c] = (sg >= SEG_COUNT || wv >= WEDGE_COUNT) ? 1 : 0;
            rq = (sg >= SEG_COUNT) ? "R6" : (wv >= WEDGE_COUNT) ? "R7" : (ph ? "R3" : "R2");
            e_req[slot][c] = {rq, "/", tag};
        end
        e_vld[slot] = 1'b1;
        cyc++;
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int t = 0; t < NTRK; t++) mw[t] = 0;
        for (int i = 0; i < 4; i++) e_vld[i] = 1'b0;
        rst = 1'b1; xing_start = 1'b0; chan_in = '1; wedge_in = '1;
        repeat (4) @(negedge clk);
        chk(pt_out == '0, "R8 pt reset", int'(pt_out[8:0]), 0);
        chk(lin_out == '0, "R8 lin reset", int'(lin_out[8:0]), 0);
        chk(err_out == '0, "R8 err reset", int'(err_out), 0);
        chk(!out_half, "R8 half reset", int'(out_half), 0);
        rst = 1'b0;
        ph_next = 1'b0;

        // boundary values: 287 maximum and 0 minimum
        drive(1'b1, ch3(11, 0, 5, 500), w6(23, 0, 12, 23, 0, 7), "edge");
        drive(1'b0, ch3(11, 0, 3, 100), w6(0, 0, 0, 0, 0, 0), "edge");
        // invalid segments and wedges
        drive(1'b1, ch3(12, 15, 4, 7), w6(5, 6, 24, 31, 3, 23), "bad");
        drive(1'b0, ch3(0, 11, 2, 9), w6(1, 1, 1, 1, 1, 1), "bad");
        // R4: load then hold while wedge_in churns
        drive(1'b1, ch3(1, 2, 3, 40), w6(1, 2, 3, 4, 5, 6), "R4 load");
        for (int i = 0; i < 6; i++)
            drive(1'b0, rnd_ch(), rnd_w(), "R4 hold");
        // R5: strobe where phase would be second half, then a normal crossing
        drive(1'b1, ch3(4, 5, 6, 60), w6(10, 11, 12, 13, 14, 15), "R5 first");
        drive(1'b1, ch3(7, 8, 9, 70), w6(20, 21, 22, 2, 3, 4), "R5 restart");
        drive(1'b0, ch3(10, 11, 0, 80), w6(0, 0, 0, 0, 0, 0), "R5 after");
        drive(1'b1, ch3(1, 1, 1, 90), w6(9, 9, 9, 8, 8, 8), "R5 normal");
        drive(1'b0, ch3(2, 2, 2, 95), w6(0, 0, 0, 0, 0, 0), "R5 normal");

        // random traffic with regular and mid-crossing strobes
        for (int i = 0; i < 3000; i++) begin
            bit s;
            s = (ph_next == 1'b0) ? ($urandom % 6 != 0) : ($urandom % 8 == 0);
            drive(s, rnd_ch(), rnd_w(), "rand");
        end
        for (int i = 0; i < 4; i++)
            drive(1'b0, '0, '0, "drain");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule